// File: doc/BRIEF.md
# Configuration Data Port Controller

This block bridges a host register bus to the word interface of an FPGA configuration engine. The host reaches it through a simple synchronous register bus, decoded from configuration-space cycles. Through that bus it can push a bitstream into the engine one 32-bit word at a time, or pull readback words out of it. The bus carries an address, a write strobe, a read strobe and 32-bit write and read data. A control/status register at offset 0x40 and a data register at offset 0x44 are the only decoded locations.

Loading uses a single holding word. Its empty flag tells the host when the word has been handed across a valid/ready handshake to the configuration logic. Readback shares the same data register. The host drives an active-low mode bit low to enter readback mode. The configuration side then offers words under a valid/ready pair, and a full flag tells the host that a word is waiting. The readback path is re-armed by a fixed write sequence, which ends in a one-cycle re-arm pulse toward the configuration logic. Bitstream words are MSB-first: bit 31 of the data register is the first bit of each 32-bit group of the serial stream.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset, a read of offset 0x40 shows bit 4 (empty) = 1, bit 5 (full) = 0, bits 3/9/10 = 0, bit 13 = 1 and bit 14 = 0. ld_valid_o, rb_mode_o and rb_rearm_o are 0.
- R2: Status bits 0, 1 and 2 read live as: not boundary-scan-owned (inverse of jtag_owns_i), cfg_done_i and cfg_init_i.
- R3: In load mode (bit 13 = 1), a write to 0x44 while empty = 1 takes the word. From the next cycle, ld_valid_o = 1, ld_data_o equals the word with bit 31 as the first serial bit, and empty reads 0.
- R4: A clock edge with ld_valid_o = 1 and ld_ready_i = 1 hands the word over. ld_valid_o is 0 and empty reads 1 from the next cycle. Without ld_ready_i the word and ld_valid_o hold.
- R5: A load-mode write to 0x44 while empty = 0 is refused. It sets the handshake-error flag (bit 3) and leaves ld_data_o unchanged.
- R6: Pulses on bit_err_a_i and bit_err_b_i set sticky flags at bits 9 and 10. A control write with 0 in those bits leaves them set.
- R7: Writing 1 to bit 3, 9 or 10 of 0x40 clears that flag.
- R8: With bit 13 written to 0, rb_mode_o = 1, and rb_ready_o = 1 while full = 0. A word taken under rb_valid_i and rb_ready_o sets full, and rb_ready_o drops on the next cycle. Words offered while full = 1 are not taken.
- R9: In readback mode, a read of 0x44 returns the waiting word in that cycle, and full reads 0 from the next cycle.
- R10: In readback mode, writes to 0x44 do not reach the load path: ld_valid_o stays 0 and bit 3 stays 0.
- R11: The re-arm sequence gives exactly one cycle of rb_rearm_o, on the cycle after the final control write, and clears full. The sequence is: bit 13 = 0 and bit 14 = 1, then a write of 0xFFFFFFFF to 0x44, then a control write with bit 14 = 0. Leaving out the 0xFFFFFFFF write gives no pulse.
- R12: Reads of any other offset return 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of reg_rd_i |
| ld_valid_o | output | 1 | Load word pending |
| ld_ready_i | input | 1 | Configuration logic accepts the load word |
| ld_data_o | output | 32 | Load word, bit 31 first |
| rb_valid_i | input | 1 | Readback word offered |
| rb_ready_o | output | 1 | Readback word can be taken |
| rb_data_i | input | 32 | Readback word |
| rb_mode_o | output | 1 | Readback mode active |
| cfg_req_o | output | 1 | Configure-request control bit |
| rb_rearm_o | output | 1 | One-cycle readback re-arm pulse |
| jtag_owns_i | input | 1 | Boundary-scan controller owns configuration |
| cfg_done_i | input | 1 | Configuration completed |
| cfg_init_i | input | 1 | Init status |
| bit_err_a_i | input | 1 | Bitstream error pulse A |
| bit_err_b_i | input | 1 | Bitstream error pulse B |

## Verification
The checker watches the handshake rules on every cycle. An offered load word holds while it waits and drops after acceptance. A readback capture blocks further captures on the next cycle. rb_ready_o implies readback mode, readback-mode data writes never raise a load, and the re-arm pulse never lasts two cycles. Only the bench scenarios can show what the register encodings read back: the sticky-flag and write-one-to-clear behaviour, the refusal of an overlapping write with its error flag, and the full flag cleared by a host read. They are also needed to show that the complete re-arm sequence fires while a partial one does not.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned B_NSCAN = 0;
  localparam int unsigned B_DONE  = 1;
  localparam int unsigned B_INIT  = 2;
  localparam int unsigned B_HSERR = 3;
  localparam int unsigned B_EMPTY = 4;
  localparam int unsigned B_FULL  = 5;
  localparam int unsigned B_ERRA  = 9;
  localparam int unsigned B_ERRB  = 10;
  localparam int unsigned B_RBENN = 13;
  localparam int unsigned B_CREQ  = 14;
  localparam int unsigned N_STICKY = 3;

  typedef struct packed {
    logic rb_en_n;
    logic cfg_req;
  } ctrl_t;

  function automatic logic is_rearm_word(input logic [DATA_W-1:0] w);
    return &w;
  endfunction
endpackage

// File: rtl/cfg_port_csr.sv
module cfg_port_csr
  import cfg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_wr_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hs_err_set_i,
  input  logic              err_a_i,
  input  logic              err_b_i,
  output ctrl_t             ctrl_o,
  output logic [N_STICKY-1:0] sticky_o,
  output logic              rearm_o
);
  localparam int unsigned POS [N_STICKY] = '{B_HSERR, B_ERRA, B_ERRB};

  ctrl_t ctrl_q;
  logic  armed_q, rearm_q;
  logic [N_STICKY-1:0] set_vec;

  assign set_vec = {err_b_i, err_a_i, hs_err_set_i};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          flag_q <= 1'b0;
      else if (set_vec[g])                  flag_q <= 1'b1;
      else if (csr_wr_i && wdata_i[POS[g]]) flag_q <= 1'b0;
    end
    assign sticky_o[g] = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '{rb_en_n: 1'b1, cfg_req: 1'b0};
      armed_q <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      rearm_q <= 1'b0;
      if (data_wr_i && ctrl_q.cfg_req && !ctrl_q.rb_en_n && is_rearm_word(wdata_i))
        armed_q <= 1'b1;
      if (csr_wr_i) begin
        ctrl_q.rb_en_n <= wdata_i[B_RBENN];
        ctrl_q.cfg_req <= wdata_i[B_CREQ];
        if (ctrl_q.cfg_req && !wdata_i[B_CREQ]) begin
          rearm_q <= armed_q;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rearm_o = rearm_q;
endmodule

// File: rtl/cfg_port_load.sv
module cfg_port_load
  import cfg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              hs_err_o
);
  logic              pend_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      word_q <= '0;
    end else if (pend_q) begin
      if (ready_i) pend_q <= 1'b0;
    end else if (wr_i) begin
      pend_q <= 1'b1;
      word_q <= wdata_i;
    end
  end

  assign valid_o  = pend_q;
  assign data_o   = word_q;
  assign empty_o  = !pend_q;
  assign hs_err_o = wr_i && pend_q;
endmodule

// File: rtl/cfg_port_rdbk.sv
module cfg_port_rdbk
  import cfg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              host_rd_i,
  input  logic              flush_i,
  output logic              ready_o,
  output logic              full_o,
  output logic [DATA_W-1:0] word_o
);
  logic              full_q;
  logic [DATA_W-1:0] word_q;

  assign ready_o = mode_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (flush_i || (host_rd_i && full_q)) begin
      full_q <= 1'b0;
    end else if (valid_i && ready_o) begin
      full_q <= 1'b1;
      word_q <= data_i;
    end
  end

  assign full_o = full_q;
  assign word_o = word_q;
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  CSR_OFS  = 8'h40,
  parameter logic [7:0]  DATA_OFS = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              ld_valid_o,
  input  logic              ld_ready_i,
  output logic [31:0]       ld_data_o,
  input  logic              rb_valid_i,
  output logic              rb_ready_o,
  input  logic [31:0]       rb_data_i,
  output logic              rb_mode_o,
  output logic              cfg_req_o,
  output logic              rb_rearm_o,
  input  logic              jtag_owns_i,
  input  logic              cfg_done_i,
  input  logic              cfg_init_i,
  input  logic              bit_err_a_i,
  input  logic              bit_err_b_i
);
  localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(CSR_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  logic csr_sel, data_sel, csr_wr, data_wr, data_rd;
  logic ld_wr, hs_err_set, empty, full;
  logic [N_STICKY-1:0] sticky;
  logic [DATA_W-1:0] rb_word, status;
  ctrl_t ctrl;

  assign csr_sel  = reg_addr_i == CSR_A;
  assign data_sel = reg_addr_i == DATA_A;
  assign csr_wr   = reg_wr_i && csr_sel;
  assign data_wr  = reg_wr_i && data_sel;
  assign data_rd  = reg_rd_i && data_sel;
  assign rb_mode_o = !ctrl.rb_en_n;
  assign cfg_req_o = ctrl.cfg_req;
  assign ld_wr     = data_wr && ctrl.rb_en_n;

  cfg_port_csr u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .csr_wr_i     (csr_wr),
    .data_wr_i    (data_wr),
    .wdata_i      (reg_wdata_i),
    .hs_err_set_i (hs_err_set),
    .err_a_i      (bit_err_a_i),
    .err_b_i      (bit_err_b_i),
    .ctrl_o       (ctrl),
    .sticky_o     (sticky),
    .rearm_o      (rb_rearm_o)
  );

  cfg_port_load u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ld_wr),
    .wdata_i  (reg_wdata_i),
    .ready_i  (ld_ready_i),
    .valid_o  (ld_valid_o),
    .data_o   (ld_data_o),
    .empty_o  (empty),
    .hs_err_o (hs_err_set)
  );

  cfg_port_rdbk u_rdbk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (rb_mode_o),
    .valid_i   (rb_valid_i),
    .data_i    (rb_data_i),
    .host_rd_i (data_rd && rb_mode_o),
    .flush_i   (rb_rearm_o),
    .ready_o   (rb_ready_o),
    .full_o    (full),
    .word_o    (rb_word)
  );

  always_comb begin
    status          = '0;
    status[B_NSCAN] = !jtag_owns_i;
    status[B_DONE]  = cfg_done_i;
    status[B_INIT]  = cfg_init_i;
    status[B_HSERR] = sticky[0];
    status[B_EMPTY] = empty;
    status[B_FULL]  = full;
    status[B_ERRA]  = sticky[1];
    status[B_ERRB]  = sticky[2];
    status[B_RBENN] = ctrl.rb_en_n;
    status[B_CREQ]  = ctrl.cfg_req;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (csr_sel)        reg_rdata_o = status;
      else if (data_sel)  reg_rdata_o = rb_mode_o ? rb_word : ld_data_o;
    end
  end
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  reg_addr_i,
  input logic        reg_wr_i,
  input logic        ld_valid_o,
  input logic        ld_ready_i,
  input logic [31:0] ld_data_o,
  input logic        rb_valid_i,
  input logic        rb_ready_o,
  input logic        rb_mode_o,
  input logic        rb_rearm_o
);
  assert_hold_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o && !ld_ready_i |=> ld_valid_o && $stable(ld_data_o));

  assert_drop_after_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o && ld_ready_i |=> !ld_valid_o);

  assert_ready_needs_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_ready_o |-> rb_mode_o);

  assert_capture_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_valid_i && rb_ready_o |=> !rb_ready_o);

  assert_no_load_in_rb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == 8'h44 && rb_mode_o && !ld_valid_o |=> !ld_valid_o);

  assert_rearm_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_rearm_o |=> !rb_rearm_o);
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .ld_valid_o (ld_valid_o),
  .ld_ready_i (ld_ready_i),
  .ld_data_o  (ld_data_o),
  .rb_valid_i (rb_valid_i),
  .rb_ready_o (rb_ready_o),
  .rb_mode_o  (rb_mode_o),
  .rb_rearm_o (rb_rearm_o)
);

// File: tb/cfg_port_ctrl_tb_top.sv
module cfg_port_ctrl_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        ld_valid, ld_ready = 1'b0;
  logic [31:0] ld_data;
  logic        rb_valid = 1'b0, rb_ready;
  logic [31:0] rb_data = '0;
  logic        rb_mode, cfg_req, rearm;
  logic        jtag = 1'b0, done = 1'b0, init = 1'b1, erra = 1'b0, errb = 1'b0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  cfg_port_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ld_valid_o(ld_valid),
    .ld_ready_i(ld_ready), .ld_data_o(ld_data), .rb_valid_i(rb_valid),
    .rb_ready_o(rb_ready), .rb_data_i(rb_data), .rb_mode_o(rb_mode),
    .cfg_req_o(cfg_req), .rb_rearm_o(rearm), .jtag_owns_i(jtag),
    .cfg_done_i(done), .cfg_init_i(init), .bit_err_a_i(erra), .bit_err_b_i(errb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 8'h00;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; addr = 8'h00;
  endtask

  task automatic t_reset;
    reg_read(8'h40, v);
    check("R1 status", v, 32'h0000_2015);
    check("R1 outputs", {29'd0, ld_valid, rb_mode, rearm}, 32'd0);
  endtask

  task automatic t_status;
    jtag = 1'b1; done = 1'b1; init = 1'b0;
    reg_read(8'h40, v);
    check("R2 live bits", {29'd0, v[2:0]}, 32'd2);
    jtag = 1'b0; done = 1'b0; init = 1'b1;
    reg_read(8'h40, v);
    check("R2 live bits back", {29'd0, v[2:0]}, 32'd5);
  endtask

  task automatic t_load;
    reg_write(8'h44, 32'hFFF2_04D8);
    check("R3 valid", {31'd0, ld_valid}, 32'd1);
    check("R3 data msb-first", ld_data, 32'hFFF2_04D8);
    reg_read(8'h40, v);
    check("R3 empty low", {31'd0, v[4]}, 32'd0);
    reg_write(8'h44, 32'h1234_5678);
    check("R5 word kept", ld_data, 32'hFFF2_04D8);
    reg_read(8'h40, v);
    check("R5 hs err", {31'd0, v[3]}, 32'd1);
    @(negedge clk); ld_ready = 1'b1;
    @(negedge clk); ld_ready = 1'b0;
    check("R4 valid drop", {31'd0, ld_valid}, 32'd0);
    reg_read(8'h40, v);
    check("R4 empty", {31'd0, v[4]}, 32'd1);
    reg_write(8'h40, 32'h0000_2008);
    reg_read(8'h40, v);
    check("R7 hs err clear", {31'd0, v[3]}, 32'd0);
  endtask

  task automatic t_sticky;
    @(negedge clk); erra = 1'b1;
    @(negedge clk); erra = 1'b0; errb = 1'b1;
    @(negedge clk); errb = 1'b0;
    reg_write(8'h40, 32'h0000_2000);
    reg_read(8'h40, v);
    check("R6 sticky", {30'd0, v[10:9]}, 32'd3);
    reg_write(8'h40, 32'h0000_2200);
    reg_read(8'h40, v);
    check("R7 clear a only", {30'd0, v[10:9]}, 32'd2);
    reg_write(8'h40, 32'h0000_2400);
    reg_read(8'h40, v);
    check("R7 clear b", {30'd0, v[10:9]}, 32'd0);
  endtask

  task automatic t_readback;
    reg_write(8'h40, 32'h0000_0000);
    check("R8 mode/ready", {30'd0, rb_mode, rb_ready}, 32'd3);
    @(negedge clk); rb_valid = 1'b1; rb_data = 32'hC0FF_5FFF;
    @(negedge clk); rb_data = 32'hBAD0_0BAD;
    check("R8 ready drop", {31'd0, rb_ready}, 32'd0);
    @(negedge clk); rb_valid = 1'b0;
    reg_read(8'h40, v);
    check("R8 full", {31'd0, v[5]}, 32'd1);
    reg_read(8'h44, v);
    check("R9 word", v, 32'hC0FF_5FFF);
    reg_read(8'h40, v);
    check("R9 full clear", {31'd0, v[5]}, 32'd0);
    reg_write(8'h44, 32'h1111_1111);
    reg_read(8'h40, v);
    check("R10 no load", {30'd0, ld_valid, v[3]}, 32'd0);
  endtask

  task automatic t_rearm;
    @(negedge clk); rb_valid = 1'b1; rb_data = 32'h0F0F_0F0F;
    @(negedge clk); rb_valid = 1'b0;
    reg_write(8'h40, 32'h0000_4000);
    reg_write(8'h40, 32'h0000_0000);
    check("R11 no pulse w/o word", {31'd0, rearm}, 32'd0);
    reg_write(8'h40, 32'h0000_4000);
    check("R11 cfg req", {31'd0, cfg_req}, 32'd1);
    reg_write(8'h44, 32'hFFFF_FFFF);
    reg_write(8'h40, 32'h0000_0000);
    check("R11 pulse", {31'd0, rearm}, 32'd1);
    @(negedge clk);
    check("R11 pulse one cycle", {31'd0, rearm}, 32'd0);
    reg_read(8'h40, v);
    check("R11 full cleared", {31'd0, v[5]}, 32'd0);
  endtask

  task automatic t_other;
    reg_write(8'h48, 32'h0000_6000);
    reg_read(8'h48, v);
    check("R12 other read", v, 32'd0);
    reg_read(8'h40, v);
    check("R12 ctrl untouched", {30'd0, v[14:13]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status();
    t_load();
    t_sticky();
    t_readback();
    t_rearm();
    t_other();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule